// File: doc/BRIEF.md
# Cartridge-to-Memory DMA Engine

This block copies halfwords between a cartridge-side bus and main memory without CPU involvement. The CPU programs it through a small register window. It sets a main-memory address and a cartridge address, then writes a length into one of two length registers. The register chosen picks the direction. The length write itself launches the copy; there is no separate start bit.

During a copy the engine reads one halfword from the source port, then writes it to the destination port. After each halfword it steps both address counters by two. A status register reports busy and a fault flag, and a level interrupt rises when the last halfword has been stored. Software polls status until it reads zero before it programs the next copy.

The address counters are left where the copy ended. A second copy issued without reprogramming an address therefore continues from the end of the previous one. Both memory-side ports use a simple synchronous request/acknowledge handshake.

Top module: `cart_dma_engine`

## Requirements
- R1: After a synchronous reset, the following are all zero: `irq`, both request outputs, the status word and both address registers.
- R2: The address registers sit at register offsets 0x00 (main memory) and 0x04 (cartridge). Each reads back what was written, with bit 0 forced to zero. The main-memory register keeps only its low MEM_AW bits, so the upper bits of a CPU mirror address are dropped.
- R3: A write to offset 0x0C starts a copy from cartridge to memory. For each halfword the engine reads the cartridge port (`cart_we`=0), then writes the same value to the memory port (`mem_we`=1).
- R4: A write to offset 0x08 starts a copy from memory to cartridge, with the same sequencing and the roles of the ports swapped.
- R5: A length value L moves (L>>1)+1 halfwords, which is L+1 bytes for odd L. Bit 0 of L is ignored.
- R6: Both addresses advance by 2 per halfword moved. After a copy, each address register reads the address just past the last halfword. A following copy that is issued without rewriting the addresses continues from those values.
- R7: The status word at offset 0x10 has busy in bit 0 and error in bit 1; all other bits are zero. Busy reads 1 from the cycle after the length write until the final destination acknowledge. Status reads zero when the engine is idle and has no fault.
- R8: A length write made while busy is dropped and sets the error bit. The copy already running completes unchanged.
- R9: A write to offset 0x10 never starts a copy. It clears both the error bit and the interrupt.
- R10: `irq` is set once the final halfword of a copy is stored. It stays high until a status write.
- R11: A request stays high, with its address and write flag stable, until it is acknowledged. At most one of the two ports requests at a time.
- R12: Writes to either address register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| irq | output | 1 | Level interrupt, copy finished |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write (1) or read (0) |
| mem_addr | output | MEM_AW | Main-memory byte address |
| mem_wdata | output | DATA_W | Main-memory write data |
| mem_rdata | input | DATA_W | Main-memory read data, valid with ack |
| mem_ack | input | 1 | Main-memory acknowledge |
| cart_req | output | 1 | Cartridge request |
| cart_we | output | 1 | Cartridge write (1) or read (0) |
| cart_addr | output | CART_AW | Cartridge byte address |
| cart_wdata | output | DATA_W | Cartridge write data |
| cart_rdata | input | DATA_W | Cartridge read data, valid with ack |
| cart_ack | input | 1 | Cartridge acknowledge |

## Verification
The hardest case to reach is a register write that lands while a copy is in flight. This covers both a second length write, which must be dropped and flag an error, and an address write, which must not disturb the running counters. The stimulus starts a long copy and issues these writes on the following cycles. Both bus models withhold acknowledges at random, which stretches the copy so that the window stays open. Stale-address reuse is reached by chaining copies that are programmed with a length write alone.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_MEM_ADDR  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CART_ADDR = 5'h04;
  localparam logic [REG_AW-1:0] OFS_LEN_TOCART = 5'h08;
  localparam logic [REG_AW-1:0] OFS_LEN_TOMEM  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS    = 5'h10;

  typedef enum logic {
    DIR_TO_MEM  = 1'b0,
    DIR_TO_CART = 1'b1
  } xfer_dir_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_STORE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cart_dma_regs.sv
module cart_dma_regs
  import cart_dma_pkg::*;
#(
  parameter int MEM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  input  logic               busy,
  input  logic               done,
  input  logic [MEM_AW-1:0]  mem_addr_cur,
  input  logic [CART_AW-1:0] cart_addr_cur,
  output logic               ld_mem,
  output logic [MEM_AW-1:0]  ld_mem_val,
  output logic               ld_cart,
  output logic [CART_AW-1:0] ld_cart_val,
  output logic               start,
  output xfer_dir_e          start_dir,
  output logic [LEN_W-1:0]   start_hw
);
  logic        err_q, irq_q;
  logic [31:0] rdata_q;
  logic        len_wr, stat_wr;

  assign len_wr  = reg_we && (reg_addr == OFS_LEN_TOMEM || reg_addr == OFS_LEN_TOCART);
  assign stat_wr = reg_we && (reg_addr == OFS_STATUS);

  assign ld_mem      = reg_we && !busy && (reg_addr == OFS_MEM_ADDR);
  assign ld_cart     = reg_we && !busy && (reg_addr == OFS_CART_ADDR);
  assign ld_mem_val  = {reg_wdata[MEM_AW-1:1], 1'b0};
  assign ld_cart_val = {reg_wdata[CART_AW-1:1], 1'b0};

  assign start     = len_wr && !busy;
  assign start_dir = (reg_addr == OFS_LEN_TOCART) ? DIR_TO_CART : DIR_TO_MEM;
  assign start_hw  = {1'b0, reg_wdata[LEN_W-1:1]} + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (reg_addr)
        OFS_MEM_ADDR:  rdata_q <= 32'(mem_addr_cur);
        OFS_CART_ADDR: rdata_q <= 32'(cart_addr_cur);
        OFS_STATUS:    rdata_q <= {30'd0, err_q, busy};
        default:       rdata_q <= '0;
      endcase
      if (stat_wr) begin
        err_q <= 1'b0;
        irq_q <= 1'b0;
      end
      if (len_wr && busy) err_q <= 1'b1;
      if (done) irq_q <= 1'b1;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R9: a status write on an idle engine leaves it idle
  a_r9_status_no_start: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !busy) |=> !busy);
  // R8: length write while busy raises the fault flag
  a_r8_busy_len_err: assert property (@(posedge clk) disable iff (rst)
    (len_wr && busy) |=> err_q);
  // R10: completion raises the interrupt
  a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
    done |=> irq_q);
endmodule

// File: rtl/cart_dma_seq.sv
module cart_dma_seq
  import cart_dma_pkg::*;
#(
  parameter int MEM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_mem,
  input  logic [MEM_AW-1:0]  ld_mem_val,
  input  logic               ld_cart,
  input  logic [CART_AW-1:0] ld_cart_val,
  input  logic               start,
  input  xfer_dir_e          start_dir,
  input  logic [LEN_W-1:0]   start_hw,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack,
  output logic               cart_req,
  output logic               cart_we,
  output logic [CART_AW-1:0] cart_addr,
  output logic [DATA_W-1:0]  cart_wdata,
  input  logic [DATA_W-1:0]  cart_rdata,
  input  logic               cart_ack
);
  localparam int STEP = DATA_W / 8;

  seq_state_e          state_q;
  xfer_dir_e           dir_q;
  logic [LEN_W-1:0]    remain_q;
  logic [MEM_AW-1:0]   maddr_q;
  logic [CART_AW-1:0]  caddr_q;
  logic [DATA_W-1:0]   buf_q;
  logic                mreq_q, mwe_q, creq_q, cwe_q, done_q;
  logic                src_ack, dst_ack;
  logic [DATA_W-1:0]   src_data;

  assign src_ack  = (dir_q == DIR_TO_MEM) ? cart_ack : mem_ack;
  assign dst_ack  = (dir_q == DIR_TO_MEM) ? mem_ack  : cart_ack;
  assign src_data = (dir_q == DIR_TO_MEM) ? cart_rdata : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      dir_q    <= DIR_TO_MEM;
      remain_q <= '0;
      maddr_q  <= '0;
      caddr_q  <= '0;
      buf_q    <= '0;
      mreq_q   <= 1'b0;
      mwe_q    <= 1'b0;
      creq_q   <= 1'b0;
      cwe_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld_mem)  maddr_q <= ld_mem_val;
      if (ld_cart) caddr_q <= ld_cart_val;
      unique case (state_q)
        SQ_IDLE: if (start) begin
          dir_q    <= start_dir;
          remain_q <= start_hw;
          state_q  <= SQ_FETCH;
          if (start_dir == DIR_TO_MEM) begin creq_q <= 1'b1; cwe_q <= 1'b0; end
          else begin mreq_q <= 1'b1; mwe_q <= 1'b0; end
        end
        SQ_FETCH: if (src_ack) begin
          buf_q   <= src_data;
          state_q <= SQ_STORE;
          if (dir_q == DIR_TO_MEM) begin creq_q <= 1'b0; mreq_q <= 1'b1; mwe_q <= 1'b1; end
          else begin mreq_q <= 1'b0; creq_q <= 1'b1; cwe_q <= 1'b1; end
        end
        SQ_STORE: if (dst_ack) begin
          maddr_q  <= maddr_q + MEM_AW'(STEP);
          caddr_q  <= caddr_q + CART_AW'(STEP);
          remain_q <= remain_q - LEN_W'(1);
          mreq_q   <= 1'b0;
          creq_q   <= 1'b0;
          if (remain_q == LEN_W'(1)) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= SQ_FETCH;
            if (dir_q == DIR_TO_MEM) begin creq_q <= 1'b1; cwe_q <= 1'b0; end
            else begin mreq_q <= 1'b1; mwe_q <= 1'b0; end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign done       = done_q;
  assign mem_req    = mreq_q;
  assign mem_we     = mwe_q;
  assign mem_addr   = maddr_q;
  assign mem_wdata  = buf_q;
  assign cart_req   = creq_q;
  assign cart_we    = cwe_q;
  assign cart_addr  = caddr_q;
  assign cart_wdata = buf_q;

  // R11: only one port is addressed at a time
  a_r11_single_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mreq_q, creq_q}));
  // R11: memory request held steady until acknowledged
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mreq_q && !mem_ack) |=> (mreq_q && $stable(maddr_q) && $stable(mwe_q)));
  // R11: cartridge request held steady until acknowledged
  a_r11_cart_hold: assert property (@(posedge clk) disable iff (rst)
    (creq_q && !cart_ack) |=> (creq_q && $stable(caddr_q) && $stable(cwe_q)));
  // R1: an idle engine drives no request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mreq_q && !creq_q));
endmodule

// File: rtl/cart_dma_engine.sv
module cart_dma_engine
  import cart_dma_pkg::*;
#(
  parameter int MEM_AW  = 24,
  parameter int CART_AW = 32,
  parameter int LEN_W   = 24,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack,
  output logic               cart_req,
  output logic               cart_we,
  output logic [CART_AW-1:0] cart_addr,
  output logic [DATA_W-1:0]  cart_wdata,
  input  logic [DATA_W-1:0]  cart_rdata,
  input  logic               cart_ack
);
  logic               busy, done, ld_mem, ld_cart, start;
  logic [MEM_AW-1:0]  ld_mem_val;
  logic [CART_AW-1:0] ld_cart_val;
  logic [LEN_W-1:0]   start_hw;
  xfer_dir_e          start_dir;

  cart_dma_regs #(
    .MEM_AW(MEM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .busy(busy), .done(done),
    .mem_addr_cur(mem_addr), .cart_addr_cur(cart_addr),
    .ld_mem(ld_mem), .ld_mem_val(ld_mem_val),
    .ld_cart(ld_cart), .ld_cart_val(ld_cart_val),
    .start(start), .start_dir(start_dir), .start_hw(start_hw)
  );

  cart_dma_seq #(
    .MEM_AW(MEM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .ld_mem(ld_mem), .ld_mem_val(ld_mem_val),
    .ld_cart(ld_cart), .ld_cart_val(ld_cart_val),
    .start(start), .start_dir(start_dir), .start_hw(start_hw),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_ack(cart_ack)
  );
endmodule

// File: tb/cart_dma_engine_tb_top.sv
`timescale 1ns/1ps
module cart_dma_engine_tb_top;
  localparam int MEM_AW = 24, CART_AW = 32, LEN_W = 24, DATA_W = 16;
  localparam int NHW = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic mem_req, mem_we, mem_ack = 1'b0, cart_req, cart_we, cart_ack = 1'b0;
  logic [MEM_AW-1:0] mem_addr;
  logic [CART_AW-1:0] cart_addr;
  logic [DATA_W-1:0] mem_wdata, cart_wdata, mem_rdata = '0, cart_rdata = '0;

  logic [15:0] mem_arr [NHW], cart_arr [NHW], exp_mem [NHW], exp_cart [NHW];
  int wr_cnt = 0;
  int errors = 0, checks = 0;
  logic [31:0] b_mem = 0, b_cart = 0;

  always #2.5 clk = ~clk;

  cart_dma_engine #(.MEM_AW(MEM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr), .cart_wdata(cart_wdata),
    .cart_rdata(cart_rdata), .cart_ack(cart_ack));

  // bus models with random acknowledge delay
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; cart_ack <= 1'b0;
    end else begin
      mem_ack <= 1'b0; cart_ack <= 1'b0;
      if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
        mem_ack <= 1'b1;
        if (mem_we) begin mem_arr[mem_addr[9:1]] <= mem_wdata; wr_cnt = wr_cnt + 1; end
        else mem_rdata <= mem_arr[mem_addr[9:1]];
      end
      if (cart_req && !cart_ack && ($urandom % 3 != 0)) begin
        cart_ack <= 1'b1;
        if (cart_we) begin cart_arr[cart_addr[9:1]] <= cart_wdata; wr_cnt = wr_cnt + 1; end
        else cart_rdata <= cart_arr[cart_addr[9:1]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(posedge clk); @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    while (s[0]) rd(5'h10, s);
  endtask

  function automatic int count_mismatch();
    int n = 0;
    for (int i = 0; i < NHW; i++) begin
      if (mem_arr[i] !== exp_mem[i]) n++;
      if (cart_arr[i] !== exp_cart[i]) n++;
    end
    return n;
  endfunction

  // expected effect of a copy of n halfwords, based on R3..R6
  task automatic model_copy(input bit to_cart, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ma, ca;
      ma = b_mem + 32'(2 * i); ca = b_cart + 32'(2 * i);
      if (to_cart) exp_cart[ca[9:1]] = exp_mem[ma[9:1]];
      else exp_mem[ma[9:1]] = exp_cart[ca[9:1]];
    end
  endtask

  task automatic start_xfer(input bit to_cart, input logic [31:0] lenval, input int n);
    wr(to_cart ? 5'h08 : 5'h0C, lenval);
    model_copy(to_cart, n);
  endtask

  task automatic finish_xfer(input string req, input int n, input int w0);
    logic [31:0] d;
    wait_idle();
    chk(irq === 1'b1, "R10 irq after copy", 32'(irq), 1);
    chk(count_mismatch() == 0, req, 32'(count_mismatch()), 0);
    chk(wr_cnt - w0 == n, "R5 halfword count", 32'(wr_cnt - w0), 32'(n));
    b_mem = (b_mem + 32'(2 * n)) & 32'h00FF_FFFF;
    b_cart = b_cart + 32'(2 * n);
    rd(5'h00, d); chk(d == b_mem, "R6 mem addr after copy", d, b_mem);
    rd(5'h04, d); chk(d == b_cart, "R6 cart addr after copy", d, b_cart);
    wr(5'h10, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NHW; i++) begin
      mem_arr[i] = 16'($urandom); cart_arr[i] = 16'($urandom);
      exp_mem[i] = mem_arr[i]; exp_cart[i] = cart_arr[i];
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    chk(!mem_req && !cart_req, "R1 requests", {30'd0, mem_req, cart_req}, 0);
    rd(5'h10, d); chk(d == 0, "R1 status", d, 0);
    rd(5'h00, d); chk(d == 0, "R1 mem addr", d, 0);

    // R2 address registers, alignment and mirror bits
    wr(5'h00, 32'h8000_0141); rd(5'h00, d); chk(d == 32'h140, "R2 mem addr", d, 32'h140);
    wr(5'h04, 32'h1022_DFCD); rd(5'h04, d); chk(d == 32'h1022_DFCC, "R2 cart addr", d, 32'h1022_DFCC);

    // R3 directed cartridge-to-memory copy of 4 halfwords
    wr(5'h00, 32'h40); wr(5'h04, 32'h100); b_mem = 32'h40; b_cart = 32'h100;
    w0 = wr_cnt;
    start_xfer(1'b0, 32'd7, 4);
    rd(5'h10, d); chk(d == 1, "R7 busy after start", d, 1);
    chk(irq === 1'b0, "R10 irq low while busy", 32'(irq), 0);
    finish_xfer("R3 data cart to mem", 4, w0);
    rd(5'h10, d); chk(d == 0, "R7 status idle", d, 0);
    chk(irq === 1'b0, "R9 irq cleared", 32'(irq), 0);

    // R9 status write does not start anything
    w0 = wr_cnt;
    wr(5'h10, 32'hFFFF_FFFF);
    repeat (6) @(negedge clk);
    rd(5'h10, d); chk(d == 0, "R9 no start", d, 0);
    chk(wr_cnt == w0 && !mem_req && !cart_req, "R9 no traffic", 32'(wr_cnt - w0), 0);

    // R4 + R6 stale addresses reused: memory-to-cartridge, no address writes
    w0 = wr_cnt;
    start_xfer(1'b1, 32'd3, 2);
    finish_xfer("R4 data mem to cart stale addr", 2, w0);

    // R5 even length value: bit 0 ignored, 4 -> 3 halfwords
    w0 = wr_cnt;
    start_xfer(1'b0, 32'd4, 3);
    finish_xfer("R5 even length data", 3, w0);

    // R8 + R12 writes while busy
    wr(5'h00, 32'h200); wr(5'h04, 32'h20); b_mem = 32'h200; b_cart = 32'h20;
    w0 = wr_cnt;
    start_xfer(1'b0, 32'd31, 16);
    wr(5'h08, 32'd1);
    wr(5'h00, 32'h3F0);
    wr(5'h04, 32'h3F0);
    wait_idle();
    rd(5'h10, d); chk(d == 2, "R8 error bit set busy clear", d, 2);
    chk(count_mismatch() == 0, "R8 dropped length leaves copy intact", 32'(count_mismatch()), 0);
    chk(wr_cnt - w0 == 16, "R8 count unchanged", 32'(wr_cnt - w0), 16);
    rd(5'h00, d); chk(d == 32'h220, "R12 mem addr write ignored", d, 32'h220);
    rd(5'h04, d); chk(d == 32'h40, "R12 cart addr write ignored", d, 32'h40);
    wr(5'h10, 0);
    rd(5'h10, d); chk(d == 0, "R9 error cleared", d, 0);
    chk(irq === 1'b0, "R9 irq cleared after fault", 32'(irq), 0);

    // random copies in both directions (R3 R4 R5 R6 R11)
    for (int k = 0; k < 10; k++) begin
      bit dir;
      int n;
      dir = 1'($urandom);
      n = 1 + int'($urandom % 16);
      b_mem = 32'(($urandom % (NHW - n)) * 2);
      b_cart = 32'(($urandom % (NHW - n)) * 2);
      wr(5'h00, b_mem); wr(5'h04, b_cart);
      w0 = wr_cnt;
      start_xfer(dir, 32'(2 * n - 1), n);
      finish_xfer(dir ? "R4 random mem to cart" : "R3 random cart to mem", n, w0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule